// File: doc/BRIEF.md
# MIN/MAX/AVG Feedback Network Relaxation Engine

The block evaluates a small programmable network of two-input gates whose outputs may feed back into one another. Each gate computes the minimum, the maximum or the rounded mean of two operands. An operand is either another gate's output or a fixed constant of zero or one. Values are unsigned fractions of `VW` bits. The all-ones code stands for 1.0.

Software, or a neighbouring block, first loads each gate's opcode and operand selectors through a valid/ready write channel. A `start` pulse then clears the value vector to all zeros and runs update passes until one whole pass leaves every entry unchanged. Two update orders are offered. In the sequential order, one gate is rewritten per cycle, in index order. In the parallel order, every gate is rewritten in one cycle from the previous vector. A pass limit ends runs that do not settle in time. After a run, the vector stays in place and can be read back one entry at a time. A comparator reports whether a chosen entry lies strictly above one half.

Back-pressure rule for the write channel: a write is taken on a rising clock edge where both `cfg_valid` and `cfg_ready` are high. `cfg_ready` is low for the whole of a run. A producer may hold `cfg_valid` high with stable fields while it waits. A write offered while `cfg_ready` is low does not reach the gate table.

Top module: `mmx_relax_top`

## Requirements
- R1: A configuration write is taken only when `cfg_valid` and `cfg_ready` are both high on a clock edge. `cfg_ready` is low whenever `busy` is high. A write offered during a run leaves the gate table unchanged. After reset, every gate is MIN with both selectors set to constant zero.
- R2: Operand selector codes work as follows. A code below `NGATE` selects that gate's current value. Code `NGATE` selects 0. Code `NGATE+1` selects the all-ones value. Any higher code selects 0.
- R3: Opcode 0 gives the minimum of the two operands. Opcode 1 gives the maximum. Opcodes 2 and 3 give the rounded mean, (a+b+1)>>1, which never exceeds all-ones.
- R4: When `start` is high while `busy` is low, the value vector is cleared to zero, and `busy` is high from the next cycle. The update mode and the pass limit are captured at that moment. A `start` during a run is ignored.
- R5: With `mode`=0, each run cycle rewrites exactly one gate. The gates are taken in order 0 to `NGATE`-1, and each uses the values current in that cycle, including earlier rewrites in the same pass. A pass lasts `NGATE` cycles.
- R6: With `mode`=1, each run cycle rewrites all gates from the vector of the previous cycle. A pass lasts one cycle.
- R7: The first pass that changes no entry ends the run. `done` is high for exactly one cycle, and in that same cycle `busy` is low.
- R8: Suppose the pass count reaches the captured limit and the last pass still changed an entry. The run then ends with a `done` pulse, and `not_conv` rises and stays high until the next accepted `start`. A limit of 0 acts as 1.
- R9: `above_half` is high exactly when the entry selected by `probe_idx` is greater than 2^(VW-1).
- R10: `rd_val` always shows the entry selected by `rd_idx`. Outside runs, the vector does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_valid | input | 1 | Gate-table write offered |
| cfg_ready | output | 1 | Gate table accepts writes (idle) |
| cfg_gate | input | IDXW | Gate index written |
| cfg_op | input | 2 | Opcode: 0 MIN, 1 MAX, 2/3 AVG |
| cfg_sel_a | input | SELW | Operand A selector |
| cfg_sel_b | input | SELW | Operand B selector |
| start | input | 1 | Begin a run from the zero vector |
| mode | input | 1 | 0 sequential gate order, 1 whole-vector order |
| max_pass | input | PW | Pass limit (0 behaves as 1) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| not_conv | output | 1 | Last run hit the pass limit |
| probe_idx | input | IDXW | Entry compared against one half |
| above_half | output | 1 | Probed entry exceeds 2^(VW-1) |
| rd_idx | input | IDXW | Readback index |
| rd_val | output | VW | Readback value |

## Verification
The properties take `start` and `cfg_valid` to be sampled synchronously, and they take reset to begin every simulation. They also assume that the readback vector is changed only by a run. This is why the hold property is guarded by both `busy` and `start`. The stimulus drives every input half a period away from the active edge. It offers writes and start pulses during runs on purpose, so that the stall and ignore paths are exercised. It also re-runs the same feedback loop with several pass limits, including zero, so that both run endings occur.

// File: rtl/mmx_pkg.sv
package mmx_pkg;
  typedef enum logic [1:0] {
    OPC_MIN  = 2'd0,
    OPC_MAX  = 2'd1,
    OPC_MEAN = 2'd2,
    OPC_MEAN2 = 2'd3
  } opc_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_st_t;
endpackage

// File: rtl/mmx_cfg_file.sv
module mmx_cfg_file #(
  parameter int NGATE = 16,
  parameter int SELW  = 5,
  parameter int IDXW  = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [IDXW-1:0]             wr_gate,
  input  logic [1:0]                  wr_op,
  input  logic [SELW-1:0]             wr_sa,
  input  logic [SELW-1:0]             wr_sb,
  output logic [NGATE-1:0][1:0]       g_op,
  output logic [NGATE-1:0][SELW-1:0]  g_sa,
  output logic [NGATE-1:0][SELW-1:0]  g_sb
);
  localparam logic [SELW-1:0] SEL_ZERO = SELW'(NGATE);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NGATE; i++) begin
        g_op[i] <= mmx_pkg::OPC_MIN;
        g_sa[i] <= SEL_ZERO;
        g_sb[i] <= SEL_ZERO;
      end
    end else if (wr_en && (int'(wr_gate) < NGATE)) begin
      g_op[wr_gate] <= wr_op;
      g_sa[wr_gate] <= wr_sa;
      g_sb[wr_gate] <= wr_sb;
    end
  end
endmodule

// File: rtl/mmx_gate_eval.sv
module mmx_gate_eval #(
  parameter int NGATE = 16,
  parameter int VW    = 8,
  parameter int SELW  = 5,
  parameter int IDXW  = 4
) (
  input  logic [NGATE-1:0][VW-1:0] vec,
  input  logic [1:0]               op,
  input  logic [SELW-1:0]          sa,
  input  logic [SELW-1:0]          sb,
  output logic [VW-1:0]            nxt
);
  function automatic logic [VW-1:0] pick(input logic [NGATE-1:0][VW-1:0] v,
                                         input logic [SELW-1:0] s);
    logic [VW-1:0] r;
    if (int'(s) < NGATE)       r = v[s[IDXW-1:0]];
    else if (int'(s) == NGATE + 1) r = '1;
    else                       r = '0;
    return r;
  endfunction

  logic [VW-1:0] opa, opb;
  logic [VW:0]   sum;

  always_comb begin
    opa = pick(vec, sa);
    opb = pick(vec, sb);
    sum = {1'b0, opa} + {1'b0, opb} + {{VW{1'b0}}, 1'b1};
    unique case (op)
      mmx_pkg::OPC_MIN: nxt = (opa < opb) ? opa : opb;
      mmx_pkg::OPC_MAX: nxt = (opa > opb) ? opa : opb;
      default:          nxt = sum[VW:1];
    endcase
  end
endmodule

// File: rtl/mmx_value_bank.sv
module mmx_value_bank #(
  parameter int NGATE = 16,
  parameter int VW    = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clear,
  input  logic [NGATE-1:0]         upd_en,
  input  logic [NGATE-1:0][VW-1:0] nxt,
  output logic [NGATE-1:0][VW-1:0] vec
);
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      vec <= '0;
    end else begin
      for (int i = 0; i < NGATE; i++) begin
        if (upd_en[i]) vec[i] <= nxt[i];
      end
    end
  end
endmodule

// File: rtl/mmx_iter_ctrl.sv
module mmx_iter_ctrl #(
  parameter int NGATE = 16,
  parameter int PW    = 16,
  parameter int IDXW  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             mode,
  input  logic [PW-1:0]    max_pass,
  input  logic [NGATE-1:0] diff,
  output logic             busy,
  output logic             done,
  output logic             not_conv,
  output logic             clear,
  output logic [NGATE-1:0] upd_en
);
  import mmx_pkg::*;

  localparam logic [IDXW-1:0] LAST = IDXW'(NGATE - 1);

  run_st_t       st;
  logic [IDXW-1:0] ptr;
  logic [PW-1:0] pass_cnt, lim;
  logic          mode_q, chg_q;
  logic          pass_end, step_chg, any_chg, at_limit;

  assign busy  = (st == ST_RUN);
  assign clear = (st == ST_IDLE) && start;

  always_comb begin
    pass_end = mode_q || (ptr == LAST);
    step_chg = mode_q ? (|diff) : diff[ptr];
    any_chg  = chg_q || step_chg;
    at_limit = ({1'b0, pass_cnt} + {{PW{1'b0}}, 1'b1}) >= {1'b0, lim};
    upd_en   = '0;
    if (st == ST_RUN) begin
      if (mode_q) upd_en = '1;
      else        upd_en[ptr] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      ptr      <= '0;
      pass_cnt <= '0;
      lim      <= '0;
      mode_q   <= 1'b0;
      chg_q    <= 1'b0;
      done     <= 1'b0;
      not_conv <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == ST_IDLE) begin
        if (start) begin
          st       <= ST_RUN;
          ptr      <= '0;
          pass_cnt <= '0;
          chg_q    <= 1'b0;
          not_conv <= 1'b0;
          mode_q   <= mode;
          lim      <= (max_pass == '0) ? PW'(1) : max_pass;
        end
      end else begin
        if (!mode_q) ptr <= pass_end ? '0 : ptr + 1'b1;
        if (pass_end) begin
          chg_q <= 1'b0;
          if (!any_chg) begin
            st   <= ST_IDLE;
            done <= 1'b1;
          end else if (at_limit) begin
            st       <= ST_IDLE;
            done     <= 1'b1;
            not_conv <= 1'b1;
          end else begin
            pass_cnt <= pass_cnt + 1'b1;
          end
        end else begin
          chg_q <= any_chg;
        end
      end
    end
  end
endmodule

// File: rtl/mmx_relax_top.sv
module mmx_relax_top #(
  parameter int NGATE = 16,
  parameter int VW    = 8,
  parameter int PW    = 16,
  localparam int SELW = $clog2(NGATE + 2),
  localparam int IDXW = (NGATE > 1) ? $clog2(NGATE) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_valid,
  output logic            cfg_ready,
  input  logic [IDXW-1:0] cfg_gate,
  input  logic [1:0]      cfg_op,
  input  logic [SELW-1:0] cfg_sel_a,
  input  logic [SELW-1:0] cfg_sel_b,
  input  logic            start,
  input  logic            mode,
  input  logic [PW-1:0]   max_pass,
  output logic            busy,
  output logic            done,
  output logic            not_conv,
  input  logic [IDXW-1:0] probe_idx,
  output logic            above_half,
  input  logic [IDXW-1:0] rd_idx,
  output logic [VW-1:0]   rd_val
);
  localparam logic [VW-1:0] HALF = VW'(1) << (VW - 1);

  logic [NGATE-1:0][1:0]      g_op;
  logic [NGATE-1:0][SELW-1:0] g_sa, g_sb;
  logic [NGATE-1:0][VW-1:0]   vec, nxt;
  logic [NGATE-1:0]           diff, upd_en;
  logic                       clear;

  assign cfg_ready = !busy;

  mmx_cfg_file #(.NGATE(NGATE), .SELW(SELW), .IDXW(IDXW)) cfg_i (
    .clk(clk), .rst(rst), .wr_en(cfg_valid && cfg_ready),
    .wr_gate(cfg_gate), .wr_op(cfg_op), .wr_sa(cfg_sel_a), .wr_sb(cfg_sel_b),
    .g_op(g_op), .g_sa(g_sa), .g_sb(g_sb)
  );

  for (genvar gi = 0; gi < NGATE; gi++) begin : g_lane
    mmx_gate_eval #(.NGATE(NGATE), .VW(VW), .SELW(SELW), .IDXW(IDXW)) eval_i (
      .vec(vec), .op(g_op[gi]), .sa(g_sa[gi]), .sb(g_sb[gi]), .nxt(nxt[gi])
    );
    assign diff[gi] = (nxt[gi] != vec[gi]);
  end

  mmx_value_bank #(.NGATE(NGATE), .VW(VW)) bank_i (
    .clk(clk), .rst(rst), .clear(clear), .upd_en(upd_en), .nxt(nxt), .vec(vec)
  );

  mmx_iter_ctrl #(.NGATE(NGATE), .PW(PW), .IDXW(IDXW)) ctrl_i (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .max_pass(max_pass),
    .diff(diff), .busy(busy), .done(done), .not_conv(not_conv),
    .clear(clear), .upd_en(upd_en)
  );

  assign rd_val     = vec[rd_idx];
  assign above_half = vec[probe_idx] > HALF;
endmodule

// File: rtl/mmx_relax_chk.sv
module mmx_relax_chk #(
  parameter int NGATE = 16,
  parameter int VW    = 8,
  localparam int SELW = $clog2(NGATE + 2)
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       start,
  input logic                       cfg_valid,
  input logic                       busy,
  input logic                       done,
  input logic                       not_conv,
  input logic [NGATE-1:0][VW-1:0]   vec,
  input logic [NGATE-1:0][1:0]      g_op,
  input logic [NGATE-1:0][SELW-1:0] g_sa,
  input logic [NGATE-1:0][SELW-1:0] g_sb
);
  a_r1_table_frozen: assert property (@(posedge clk) disable iff (rst)
    (busy && cfg_valid) |=> ($stable(g_op) && $stable(g_sa) && $stable(g_sb)));

  a_r4_start_runs: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r7_done_ends_run: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  a_r8_flag_at_end: assert property (@(posedge clk) disable iff (rst)
    $rose(not_conv) |-> done);

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(vec));
endmodule

bind mmx_relax_top mmx_relax_chk #(.NGATE(NGATE), .VW(VW)) chk_i (
  .clk(clk), .rst(rst), .start(start), .cfg_valid(cfg_valid),
  .busy(busy), .done(done), .not_conv(not_conv),
  .vec(vec), .g_op(g_op), .g_sa(g_sa), .g_sb(g_sb)
);

// File: tb/mmx_relax_top_tb_top.sv
module mmx_relax_top_tb_top;
  localparam int NG = 16;
  localparam int VW = 8;
  localparam int PW = 16;
  localparam int SW = 5;
  localparam int IW = 4;
  localparam int ONE = 255;
  localparam int C0 = NG;
  localparam int C1 = NG + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_valid = 1'b0;
  logic cfg_ready;
  logic [IW-1:0] cfg_gate = '0;
  logic [1:0] cfg_op = '0;
  logic [SW-1:0] cfg_sel_a = '0, cfg_sel_b = '0;
  logic start = 1'b0, mode = 1'b0;
  logic [PW-1:0] max_pass = '0;
  logic busy, done, not_conv, above_half;
  logic [IW-1:0] probe_idx = '0, rd_idx = '0;
  logic [VW-1:0] rd_val;

  int n_cmp = 0, n_bad = 0, cyc = 0;

  always #10 clk = ~clk;

  mmx_relax_top #(.NGATE(NG), .VW(VW), .PW(PW)) dut_i (
    .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_gate(cfg_gate), .cfg_op(cfg_op), .cfg_sel_a(cfg_sel_a), .cfg_sel_b(cfg_sel_b),
    .start(start), .mode(mode), .max_pass(max_pass), .busy(busy), .done(done),
    .not_conv(not_conv), .probe_idx(probe_idx), .above_half(above_half),
    .rd_idx(rd_idx), .rd_val(rd_val)
  );

  // behavioural reference
  int mv[NG], mop[NG], msa[NG], msb[NG];
  bit mbusy, mdone, mnc, mmode, mchg;
  int mptr, mpass, mlim;

  function automatic int opnd(int s);
    if (s < NG) return mv[s];
    if (s == NG + 1) return ONE;
    return 0;
  endfunction

  function automatic int ev(int g);
    int a, b;
    a = opnd(msa[g]);
    b = opnd(msb[g]);
    if (mop[g] == 0) return (a < b) ? a : b;
    if (mop[g] == 1) return (a > b) ? a : b;
    return (a + b + 1) / 2;
  endfunction

  always @(posedge clk) begin : model
    int t[NG];
    int n;
    bit any, pend, was;
    if (rst) begin
      for (int i = 0; i < NG; i++) begin
        mv[i] = 0; mop[i] = 0; msa[i] = C0; msb[i] = C0;
      end
      mbusy = 0; mdone = 0; mnc = 0; mmode = 0; mchg = 0;
      mptr = 0; mpass = 0; mlim = 1;
    end else begin
      was = mbusy;
      mdone = 0;
      if (cfg_valid && !was) begin
        mop[cfg_gate] = int'(cfg_op);
        msa[cfg_gate] = int'(cfg_sel_a);
        msb[cfg_gate] = int'(cfg_sel_b);
      end
      if (!was && start) begin
        for (int i = 0; i < NG; i++) mv[i] = 0;
        mbusy = 1; mptr = 0; mpass = 0; mchg = 0; mnc = 0; mmode = mode;
        mlim = (max_pass == 0) ? 1 : int'(max_pass);
      end else if (was) begin
        any = mchg;
        if (mmode) begin
          for (int i = 0; i < NG; i++) t[i] = ev(i);
          for (int i = 0; i < NG; i++) begin
            if (t[i] != mv[i]) any = 1;
            mv[i] = t[i];
          end
          pend = 1;
        end else begin
          n = ev(mptr);
          if (n != mv[mptr]) any = 1;
          mv[mptr] = n;
          pend = (mptr == NG - 1);
          mptr = pend ? 0 : mptr + 1;
        end
        if (pend) begin
          mchg = 0;
          if (!any) begin
            mbusy = 0; mdone = 1;
          end else if (mpass + 1 >= mlim) begin
            mbusy = 0; mdone = 1; mnc = 1;
          end else begin
            mpass++;
          end
        end else begin
          mchg = any;
        end
      end
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    #2;
    if (!rst) begin
      chk(cfg_ready == !mbusy, "R1 cfg_ready", int'(cfg_ready), int'(!mbusy));
      chk(busy == mbusy, "R4 busy", int'(busy), int'(mbusy));
      chk(done == mdone, "R7 done", int'(done), int'(mdone));
      chk(not_conv == mnc, "R8 not_conv", int'(not_conv), int'(mnc));
      chk(int'(rd_val) == mv[rd_idx], "R10 rd_val", int'(rd_val), mv[rd_idx]);
      chk(above_half == (mv[probe_idx] > 128), "R9 above_half",
          int'(above_half), int'(mv[probe_idx] > 128));
    end
  end

  task automatic wr(int g, int op, int a, int b);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_gate = IW'(g); cfg_op = 2'(op);
    cfg_sel_a = SW'(a); cfg_sel_b = SW'(b);
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic clear_table();
    for (int g = 0; g < NG; g++) wr(g, 0, C0, C0);
  endtask

  task automatic run(bit md, int lim, output int ncyc);
    @(negedge clk);
    start = 1'b1; mode = md; max_pass = PW'(lim);
    ncyc = 0;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      #3;
      start = 1'b0;
      if (busy) ncyc++;
      if (done) break;
    end
  endtask

  function automatic int peek(int g);
    return mv[g];
  endfunction

  task automatic rd(int g, output int v);
    @(negedge clk);
    rd_idx = IW'(g);
    #4;
    v = int'(rd_val);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin : stim
    int nc, v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #4;
    // reset state
    chk(cfg_ready == 1'b1, "R1 reset ready", int'(cfg_ready), 1);
    chk(busy == 1'b0 && done == 1'b0 && not_conv == 1'b0, "R4 reset flags",
        int'({busy, done, not_conv}), 0);
    chk(rd_val == 0, "R10 reset value", int'(rd_val), 0);

    // R2 / R3 operand codes and opcodes, sequential mode
    wr(0, 2, C1, C0);   // mean(1,0) = 128
    wr(1, 0, 0, C1);    // min(g0,1) = 128
    wr(2, 1, 0, C0);    // max(g0,0) = 128
    wr(3, 3, C1, C1);   // mean(1,1) = 255
    wr(4, 0, C1, C1);   // min(1,1) = 255
    wr(5, 1, 20, C0);   // code 20 -> 0
    wr(6, 2, 3, 0);     // mean(255,128) = 192
    run(1'b0, 100, nc);
    rd(0, v); chk(v == 128, "R3 mean of 1 and 0", v, 128);
    rd(1, v); chk(v == 128, "R3 min", v, 128);
    rd(3, v); chk(v == 255, "R3 mean saturates at one", v, 255);
    rd(4, v); chk(v == 255, "R2 constant one", v, 255);
    rd(5, v); chk(v == 0, "R2 out-of-range code", v, 0);
    rd(6, v); chk(v == 192, "R3 mean of gates", v, 192);
    @(negedge clk); probe_idx = 4'd6; #4;
    chk(above_half == 1'b1, "R9 above half 192", int'(above_half), 1);
    @(negedge clk); probe_idx = 4'd0; #4;
    chk(above_half == 1'b0, "R9 exact half 128", int'(above_half), 0);

    // R5 / R6 chain ordering
    clear_table();
    wr(0, 1, C1, C0);
    for (int g = 1; g < NG; g++) wr(g, 1, g - 1, C0);
    run(1'b0, 100, nc);
    chk(nc == 2 * NG, "R5 sequential chain cycles", nc, 2 * NG);
    rd(NG - 1, v); chk(v == 255, "R5 chain tail", v, 255);
    run(1'b1, 100, nc);
    chk(nc == NG + 1, "R6 parallel chain cycles", nc, NG + 1);
    rd(NG - 1, v); chk(v == 255, "R6 chain tail", v, 255);
    run(1'b1, 5, nc);
    rd(4, v); chk(v == 255, "R6 parallel front after 5", v, 255);
    rd(5, v); chk(v == 0, "R6 parallel wave stops at 5", v, 0);
    chk(not_conv == 1'b1, "R8 chain limit", int'(not_conv), 1);

    // R7 / R8 self loop mean(g0,1)
    clear_table();
    wr(0, 2, 0, C1);
    run(1'b1, 100, nc);
    chk(nc == 9 && not_conv == 1'b0, "R7 loop settles", nc, 9);
    rd(0, v); chk(v == 255, "R7 loop value", v, 255);
    run(1'b1, 3, nc);
    rd(0, v); chk(v == 224 && not_conv, "R8 limit 3", v, 224);
    run(1'b0, 0, nc);
    rd(0, v); chk(v == 128 && not_conv, "R8 limit 0 as 1", v, 128);

    // R1 / R4 writes and starts offered during a run
    @(negedge clk);
    start = 1'b1; mode = 1'b1; max_pass = PW'(100);
    @(negedge clk);
    start = 1'b1;
    cfg_valid = 1'b1; cfg_gate = '0; cfg_op = 2'd0; cfg_sel_a = SW'(C0); cfg_sel_b = SW'(C0);
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      #3;
      if (done) break;
    end
    cfg_valid = 1'b0;
    rd(0, v); chk(v == 255, "R1 write during run dropped", v, 255);
    repeat (3) @(negedge clk);
    #4;
    chk(busy == 1'b0, "R4 start during run ignored", int'(busy), 0);
    run(1'b1, 100, nc);
    rd(0, v); chk(v == 255, "R1 table unchanged on rerun", v, 255);
    // R10 hold while idle
    repeat (5) @(negedge clk);
    rd(0, v); chk(v == 255, "R10 idle hold", v, 255);
    v = peek(0);

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule